// File: doc/BRIEF.md
# Dual-View Peripheral Register Decoder

This block holds the peripheral control and status registers of a small 8-bit CPU and decodes both of the CPU's ways of reaching them. Through the short I/O-port view, an opcode class (read, write, bit set, bit clear, bit test) is applied to a port address. Through the data-space view, ordinary load and store strobes reach the same registers at the port address shifted up by a fixed offset. A second, wider register window above the port range can only be reached from data space.

Some status bits are flags that hardware raises and software clears by writing a one. Single-bit set and clear are done as read-modify-write of the whole register. A set or clear aimed at a flag register therefore also clears every flag that was set when it was read. A compatibility input turns the extended window into plain byte RAM.

Top module: `dual_view_regfile`

## Requirements
- R1: `io_op` encodes 0 none, 1 read, 2 write, 3 bit set, 4 bit clear, 5 bit test. A read at a port address 0x00–0x3F returns the register on `io_rdata` in the same cycle. A write updates it at the next clock edge. `io_rdata` is zero unless a legal read is in progress.
- R2: A data-space access at port address + 0x20 (data 0x20–0x5F) reads and writes the very same register as the port view.
- R3: Bit set and bit clear at port 0x00–0x1F change only bit `io_bit` of an ordinary register. Bit test returns that bit on `io_bit_val` in the same cycle. `io_bit_val` is zero for every other operation.
- R4: Any operation at a port address of 0x40 or above, and any bit operation at 0x20 or above, raises `io_illegal` in that cycle. It returns zero on `io_rdata` and `io_bit_val` and changes no register.
- R5: With `compat` low, data addresses 0x60–0xFF form an extended register window that only data-space access reaches. Bit 7 of each of its registers reads zero. Addresses 0xF0–0xFF are reserved: they read zero and writes to them are ignored.
- R6: With `compat` high, the whole 0x60–0xFF window behaves as full 8-bit RAM.
- R7: The flag register at port 0x08 (data 0x28) has its bits set by `hw_flag_set`. Software writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R8: Bit set or bit clear on the flag register writes back the whole value that was read. Bit set on bit b clears b and every flag that was set. Bit clear on bit b clears every set flag except b.
- R9: A hardware set of a flag wins over a software clear of the same flag in the same cycle.
- R10: Port 0x3E is reserved: it reads zero and ignores writes. Port 0x10 implements only bits 3:0, and its upper bits read zero.
- R11: When a port write and a data-space write hit the same register in the same cycle, the port write takes effect.
- R12: Reset (`rst_n` low, asynchronous) clears every register and RAM byte to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| compat | input | 1 | Extended window acts as RAM when high |
| io_op | input | 3 | Port-view operation class |
| io_addr | input | 8 | Port address |
| io_bit | input | 3 | Bit index for bit operations |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data |
| io_bit_val | output | 1 | Bit-test result |
| io_illegal | output | 1 | Illegal port access this cycle |
| ds_addr | input | 8 | Data-space address |
| ds_rd | input | 1 | Data-space read strobe |
| ds_wr | input | 1 | Data-space write strobe |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| hw_flag_set | input | 8 | Hardware flag set requests |

## Verification
The bench builds the block with its default parameters. The flag register therefore sits at port 0x08, inside the bit-addressable range, so the read-modify-write side effect on flags can be driven by bit set and bit clear. The partly implemented register at 0x10 and the reserved port at 0x3E both fall in the range the data-space view reaches. With an 8-bit data address, the extended window covers exactly 0x60–0xFF and its reserved tail starts at 0xF0, so switching to compatibility mode visibly changes what those addresses read back.

// File: rtl/dual_view_regfile.sv
module dual_view_regfile #(
  parameter int IOA_W        = 8,
  parameter int DS_AW        = 8,
  parameter int IO_N         = 64,
  parameter int BIT_N        = 32,
  parameter int DS_OFS       = 32,
  parameter int EXT_LO       = 96,
  parameter int FLAG_ADDR    = 8,
  parameter int PART_ADDR    = 16,
  parameter logic [7:0] PART_MASK = 8'h0F,
  parameter int RSV_ADDR     = 62,
  parameter logic [7:0] EXT_MASK  = 8'h7F,
  parameter int EXT_RSV_FROM = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             compat,
  input  logic [2:0]       io_op,
  input  logic [IOA_W-1:0] io_addr,
  input  logic [2:0]       io_bit,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  output logic             io_bit_val,
  output logic             io_illegal,
  input  logic [DS_AW-1:0] ds_addr,
  input  logic             ds_rd,
  input  logic             ds_wr,
  input  logic [7:0]       ds_wdata,
  output logic [7:0]       ds_rdata,
  input  logic [7:0]       hw_flag_set
);
  localparam int IO_AW = $clog2(IO_N);
  localparam int EXT_N = (1 << DS_AW) - EXT_LO;
  localparam logic [IOA_W-1:0] IO_LIM  = IOA_W'(IO_N);
  localparam logic [IOA_W-1:0] BIT_LIM = IOA_W'(BIT_N);
  localparam logic [DS_AW-1:0] DS_LO   = DS_AW'(DS_OFS);
  localparam logic [DS_AW-1:0] DS_HI   = DS_AW'(DS_OFS + IO_N - 1);
  localparam logic [DS_AW-1:0] EXT_LO_A = DS_AW'(EXT_LO);
  localparam logic [DS_AW-1:0] EXT_RSV_A = DS_AW'(EXT_RSV_FROM);

  localparam logic [2:0] OP_NONE = 3'd0, OP_IN = 3'd1, OP_OUT = 3'd2,
                         OP_SET = 3'd3, OP_CLR = 3'd4, OP_TST = 3'd5;

  function automatic logic [7:0] port_mask(input int a);
    if (a == RSV_ADDR)  return 8'h00;
    if (a == PART_ADDR) return PART_MASK;
    return 8'hFF;
  endfunction

  logic [7:0] port_q [IO_N];
  logic [7:0] ext_q  [EXT_N];

  // port view decode
  logic             bit_op, io_ok, io_we;
  logic [IO_AW-1:0] io_idx;
  logic [7:0]       io_cur, bsel, io_wval;

  assign bit_op     = (io_op == OP_SET) || (io_op == OP_CLR) || (io_op == OP_TST);
  assign io_illegal = (io_op != OP_NONE) &&
                      ((io_addr >= IO_LIM) || (bit_op && io_addr >= BIT_LIM));
  assign io_ok      = (io_op != OP_NONE) && !io_illegal;
  assign io_idx     = io_addr[IO_AW-1:0];
  assign io_cur     = port_q[io_idx] & port_mask(int'(io_idx));
  assign bsel       = 8'd1 << io_bit;
  assign io_we      = io_ok && (io_op == OP_OUT || io_op == OP_SET || io_op == OP_CLR);
  assign io_wval    = (io_op == OP_OUT) ? io_wdata :
                      (io_op == OP_SET) ? (io_cur | bsel) : (io_cur & ~bsel);
  assign io_rdata   = (io_ok && io_op == OP_IN) ? io_cur : 8'h00;
  assign io_bit_val = io_ok && (io_op == OP_TST) && |(io_cur & bsel);

  // data-space decode
  logic             ds_port, ds_ext, ds_we_port, ds_we_ext;
  logic [DS_AW-1:0] ds_off, ext_off;
  logic [IO_AW-1:0] ds_idx;
  logic [7:0]       ext_msk, ext_cur;

  assign ds_port    = (ds_addr >= DS_LO) && (ds_addr <= DS_HI);
  assign ds_ext     = (ds_addr >= EXT_LO_A);
  assign ds_off     = ds_addr - DS_LO;
  assign ds_idx     = ds_off[IO_AW-1:0];
  assign ext_off    = ds_addr - EXT_LO_A;
  assign ext_msk    = compat ? 8'hFF : ((ds_addr >= EXT_RSV_A) ? 8'h00 : EXT_MASK);
  assign ext_cur    = ext_q[ext_off] & ext_msk;
  assign ds_we_port = ds_wr && ds_port;
  assign ds_we_ext  = ds_wr && ds_ext;
  assign ds_rdata   = !ds_rd ? 8'h00 :
                      ds_port ? (port_q[ds_idx] & port_mask(int'(ds_idx))) :
                      ds_ext  ? ext_cur : 8'h00;

  // flag write path, also seen by the checker
  logic       flag_io_hit, flag_wr;
  logic [7:0] flag_wval, flag_q;
  assign flag_io_hit = io_we && (io_idx == IO_AW'(FLAG_ADDR));
  assign flag_wr     = flag_io_hit || (ds_we_port && ds_idx == IO_AW'(FLAG_ADDR));
  assign flag_wval   = flag_io_hit ? io_wval : ds_wdata;
  assign flag_q      = port_q[FLAG_ADDR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < IO_N; i++) port_q[i] <= 8'h00;
    end else begin
      for (int i = 0; i < IO_N; i++) begin
        if (i == FLAG_ADDR) begin
          port_q[i] <= (port_q[i] & ~(flag_wr ? flag_wval : 8'h00)) | hw_flag_set;
        end else if (io_we && io_idx == IO_AW'(i)) begin
          port_q[i] <= io_wval & port_mask(i);
        end else if (ds_we_port && ds_idx == IO_AW'(i)) begin
          port_q[i] <= ds_wdata & port_mask(i);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < EXT_N; i++) ext_q[i] <= 8'h00;
    end else if (ds_we_ext && ext_msk != 8'h00) begin
      ext_q[ext_off] <= ds_wdata & ext_msk;
    end
  end
endmodule

// File: rtl/dual_view_regfile_chk.sv
module dual_view_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] io_op,
  input logic [7:0] io_addr,
  input logic [7:0] io_rdata,
  input logic       io_bit_val,
  input logic       io_illegal,
  input logic [7:0] hw_flag_set,
  input logic [7:0] flag_q,
  input logic       flag_wr,
  input logic [7:0] flag_wval
);
  // R4
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_illegal |-> (io_rdata == 8'h00 && !io_bit_val));

  // R4
  port_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_op != 3'd0 && io_addr >= 8'h40) |-> io_illegal);

  // R3
  test_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_op != 3'd5) |-> !io_bit_val);

  // R9
  hw_flag_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_flag_set != 8'h00) |=> ((flag_q & $past(hw_flag_set)) == $past(hw_flag_set)));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && hw_flag_set == 8'h00) |=> $stable(flag_q));

  // R7
  flag_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && flag_wval == 8'h00 && hw_flag_set == 8'h00) |=> $stable(flag_q));
endmodule

bind dual_view_regfile dual_view_regfile_chk u_chk (.*);

// File: tb/dual_view_regfile_bench.sv
module dual_view_regfile_bench;
  logic clk = 1'b0, rst_n = 1'b0, compat = 1'b0;
  logic [2:0] io_op = 3'd0, io_bit = 3'd0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00, ds_addr = 8'h00, ds_wdata = 8'h00;
  logic ds_rd = 1'b0, ds_wr = 1'b0;
  logic [7:0] hw_flag_set = 8'h00;
  logic [7:0] io_rdata, ds_rdata;
  logic io_bit_val, io_illegal;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  dual_view_regfile u_dual_view_regfile (.*);

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] op;  logic [7:0] ioa; logic [2:0] bn; logic [7:0] iwd;
    logic dsr; logic dsw; logic [7:0] dsa; logic [7:0] dwd;
    logic [7:0] erd; logic ebv; logic eil; logic [7:0] edr;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{4'd1,  3'd2, 8'h05, 3'd0, 8'hA5, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R1
    '{4'd1,  3'd1, 8'h05, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b0, 8'h00}, // R1
    '{4'd2,  3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0, 8'h25, 8'h00, 8'h00, 1'b0, 1'b0, 8'hA5}, // R2
    '{4'd2,  3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1, 8'h3A, 8'h3C, 8'h00, 1'b0, 1'b0, 8'h00}, // R2
    '{4'd2,  3'd1, 8'h1A, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h3C, 1'b0, 1'b0, 8'h00}, // R2
    '{4'd3,  3'd3, 8'h1A, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R3
    '{4'd3,  3'd1, 8'h1A, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h3D, 1'b0, 1'b0, 8'h00}, // R3
    '{4'd3,  3'd4, 8'h1A, 3'd5, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R3
    '{4'd3,  3'd1, 8'h1A, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h1D, 1'b0, 1'b0, 8'h00}, // R3
    '{4'd3,  3'd5, 8'h1A, 3'd4, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00}, // R3
    '{4'd3,  3'd5, 8'h1A, 3'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R3
    '{4'd4,  3'd2, 8'h45, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R4
    '{4'd4,  3'd1, 8'h05, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'hA5, 1'b0, 1'b0, 8'h00}, // R4
    '{4'd4,  3'd3, 8'h25, 3'd0, 8'h00, 1'b1, 1'b0, 8'h45, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R4
    '{4'd4,  3'd1, 8'h25, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R4
    '{4'd4,  3'd5, 8'h30, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R4
    '{4'd5,  3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1, 8'h70, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00}, // R5
    '{4'd5,  3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0, 8'h70, 8'h00, 8'h00, 1'b0, 1'b0, 8'h7F}, // R5
    '{4'd5,  3'd1, 8'h70, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00}, // R5
    '{4'd5,  3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1, 8'hF5, 8'h55, 8'h00, 1'b0, 1'b0, 8'h00}, // R5
    '{4'd5,  3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0, 8'hF5, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R5
    '{4'd10, 3'd2, 8'h10, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R10
    '{4'd10, 3'd1, 8'h10, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h0F, 1'b0, 1'b0, 8'h00}, // R10
    '{4'd10, 3'd2, 8'h3E, 3'd0, 8'h77, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R10
    '{4'd10, 3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0, 8'h5E, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}, // R10
    '{4'd11, 3'd2, 8'h07, 3'd0, 8'h11, 1'b0, 1'b1, 8'h27, 8'h22, 8'h00, 1'b0, 1'b0, 8'h00}, // R11
    '{4'd11, 3'd1, 8'h07, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00, 8'h11, 1'b0, 1'b0, 8'h00}  // R11
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [7:0] a, input logic [2:0] b,
                       input logic [7:0] wd, input logic r, input logic w,
                       input logic [7:0] da, input logic [7:0] dwd);
    @(negedge clk);
    io_op = op; io_addr = a; io_bit = b; io_wdata = wd;
    ds_rd = r; ds_wr = w; ds_addr = da; ds_wdata = dwd;
    #5;
  endtask

  task automatic idle();
    drive(3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic port_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    drive(3'd1, a, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
    chk(tag, io_rdata, exp);
  endtask

  task automatic ds_rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    drive(3'd0, 8'h00, 3'd0, 8'h00, 1'b1, 1'b0, a, 8'h00);
    chk(tag, ds_rdata, exp);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    port_rd(8'h05, 8'h00, "R12 port reset");
    ds_rd_chk(8'h80, 8'h00, "R12 ext reset");
    port_rd(8'h08, 8'h00, "R12 flag reset");

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].ioa, VEC[i].bn, VEC[i].iwd,
            VEC[i].dsr, VEC[i].dsw, VEC[i].dsa, VEC[i].dwd);
      chk($sformatf("R%0d vec%0d io_rdata", VEC[i].req, i), io_rdata, VEC[i].erd);
      chk($sformatf("R%0d vec%0d bit_val", VEC[i].req, i), {7'd0, io_bit_val}, {7'd0, VEC[i].ebv});
      chk($sformatf("R%0d vec%0d illegal", VEC[i].req, i), {7'd0, io_illegal}, {7'd0, VEC[i].eil});
      chk($sformatf("R%0d vec%0d ds_rdata", VEC[i].req, i), ds_rdata, VEC[i].edr);
    end

    // R7 hardware set, write-zero, write-one clear
    @(negedge clk); io_op = 3'd0; ds_rd = 0; ds_wr = 0; hw_flag_set = 8'hA6;
    @(negedge clk); hw_flag_set = 8'h00;
    port_rd(8'h08, 8'hA6, "R7 hw set");
    drive(3'd2, 8'h08, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
    port_rd(8'h08, 8'hA6, "R7 write zero keeps");
    drive(3'd2, 8'h08, 3'd0, 8'h02, 1'b0, 1'b0, 8'h00, 8'h00);
    port_rd(8'h08, 8'hA4, "R7 write one clears");
    // R8 bit set clears every set flag
    drive(3'd3, 8'h08, 3'd0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
    port_rd(8'h08, 8'h00, "R8 set side effect");
    @(negedge clk); io_op = 3'd0; hw_flag_set = 8'hA6;
    @(negedge clk); hw_flag_set = 8'h00;
    drive(3'd4, 8'h08, 3'd1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00);
    port_rd(8'h08, 8'h02, "R8 clear side effect");
    // R9 hardware set beats software clear
    @(negedge clk); io_op = 3'd2; io_addr = 8'h08; io_wdata = 8'hFF; hw_flag_set = 8'h02;
    @(negedge clk); io_op = 3'd0; hw_flag_set = 8'h00;
    port_rd(8'h08, 8'h02, "R9 hw wins");
    // R2 flag cleared through data view
    drive(3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1, 8'h28, 8'h02);
    ds_rd_chk(8'h28, 8'h00, "R2 flag via data view");

    // R6 compatibility mode RAM
    @(negedge clk); compat = 1'b1;
    drive(3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1, 8'hF5, 8'hAA);
    ds_rd_chk(8'hF5, 8'hAA, "R6 ram reserved tail");
    drive(3'd0, 8'h00, 3'd0, 8'h00, 1'b0, 1'b1, 8'h70, 8'hFF);
    ds_rd_chk(8'h70, 8'hFF, "R6 ram full byte");
    @(negedge clk); compat = 1'b0;
    ds_rd_chk(8'h70, 8'h7F, "R5 register view mask");
    ds_rd_chk(8'hF5, 8'h00, "R5 reserved tail reads zero");

    // R12 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    #5;
    io_op = 3'd1; io_addr = 8'h05; #1;
    chk("R12 async reset port", io_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1; compat = 1'b1;
    ds_rd_chk(8'h70, 8'h00, "R12 ram cleared");
    idle();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule